// File: doc/BRIEF.md
# Character I/O Channel Unit

This unit sits beside the instruction sequencer and carries out the five peripheral instructions: connect a unit, disconnect it, send one character, send a data word and receive one character. The sequencer presents an operation code, a 6-bit unit number and the 24-bit value of the named register, then pulses `start`. The unit reports completion with a one-cycle `done` pulse. At that point it also presents the register value to write back and a `skip` flag. `skip` is high only when the operation succeeded, so the sequencer steps over the next instruction.

Toward the peripherals there is a single request channel. The unit raises `req_valid` with the unit number, operation and outgoing data, and holds it until the peripheral raises `req_ready`. On a receive, the peripheral places its character on `rsp_char` in the same cycle as `req_ready`. A table of 64 connection flags records which units are attached. An operation on a unit that is not attached fails at once without touching the channel. A peripheral that stays silent for longer than the programmable `to_limit` makes the operation fail. Connecting the keyboard unit (12, octal 14) unlocks the keyboard.

Top module: `char_io_channel`

## Requirements
- R1: After reset `busy`, `done`, `skip`, `req_valid` and `kbd_unlock` are 0 and every unit is marked as disconnected. A reset issued during a run also forgets units that were connected.
- R2: An accepted operation that needs the channel raises `req_valid` in the next cycle. `req_unit`, `req_op` and `req_data` stay steady until `req_ready` is seen or the timeout fires. The operation codes are: 0 connect, 1 disconnect, 2 send character, 3 send data, 4 receive character.
- R3: A connect (code 0) that the peripheral accepts completes with `skip`=1 and marks the unit as connected. While unit 12 is connected, `kbd_unlock` is 1.
- R4: A disconnect (code 1) of a connected unit that the peripheral accepts completes with `skip`=1 and marks the unit as disconnected. When unit 12 is disconnected, `kbd_unlock` drops to 0.
- R5: A send character (code 2) puts register bits 23:18 in `req_data` bits 5:0, with the upper bits at zero. On success, `reg_out` is the register shifted left by 6 with zeros filled in.
- R6: A send data (code 3) puts the low 12 register bits in `req_data` bits 11:0, with the upper bits at zero. On success, `reg_out` equals `reg_in`.
- R7: A receive character (code 4) that succeeds returns `rsp_char` in `reg_out` bits 5:0, with bits 23:6 cleared.
- R8: Two kinds of operation fail immediately: codes 1 to 4 on a unit that is not connected, and codes 5 to 7. They raise no request and complete in the cycle after `start`, with `skip`=0 and `reg_out` equal to `reg_in`.
- R9: If `req_ready` has not been seen after `to_limit`+1 cycles of `req_valid`, the operation completes with `skip`=0 and `reg_out` equal to `reg_in`. The connection table is left unchanged.
- R10: `done` lasts one cycle. `skip` is 1 only while `done` is 1. A `start` seen while `busy` is 1 is ignored.
- R11: `done` rises in the cycle that follows the handshake of `req_valid` and `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation |
| op | input | 3 | Operation code |
| unit | input | 6 | Peripheral unit number |
| reg_in | input | 24 | Value of the named register |
| to_limit | input | 16 | Timeout, counted in wait cycles |
| busy | output | 1 | Operation in progress or completing |
| done | output | 1 | Completion pulse |
| skip | output | 1 | Success, so the next instruction is skipped |
| reg_out | output | 24 | Register value to write back |
| req_valid | output | 1 | Request to a peripheral |
| req_unit | output | 6 | Unit addressed by the request |
| req_op | output | 3 | Operation of the request |
| req_data | output | 24 | Outgoing character or data word |
| req_ready | input | 1 | Peripheral accepts or delivers |
| rsp_char | input | 6 | Received character |
| kbd_unlock | output | 1 | Keyboard unit is connected |

## Verification
A table of operations runs the unit through a mixed sequence:
- sends and receives on attached and unattached units, which separates the immediate-fail path from the channel path;
- peripherals that answer after zero to three cycles, which separates handshake timing from the timeout;
- peripherals that never answer, which exposes the timeout length and shows that a failed connect leaves the unit detached;
- undefined operation codes.

A send character is given a register whose top and low bits differ, so that a wrong slice or a missing shift shows up. A receive is given a register of all ones, so that any upper bits left uncleared show up. Directed cases then cover the keyboard unlock, a `start` during a pending operation, and a reset that drops connections.

// File: rtl/char_io_channel.sv
module char_io_channel #(
  parameter int UNIT_W   = 6,
  parameter int REG_W    = 24,
  parameter int CHAR_W   = 6,
  parameter int DATA_W   = 12,
  parameter int TO_W     = 16,
  parameter int KBD_UNIT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [UNIT_W-1:0] unit,
  input  logic [REG_W-1:0]  reg_in,
  input  logic [TO_W-1:0]   to_limit,
  output logic              busy,
  output logic              done,
  output logic              skip,
  output logic [REG_W-1:0]  reg_out,
  output logic              req_valid,
  output logic [UNIT_W-1:0] req_unit,
  output logic [2:0]        req_op,
  output logic [REG_W-1:0]  req_data,
  input  logic              req_ready,
  input  logic [CHAR_W-1:0] rsp_char,
  output logic              kbd_unlock
);
  localparam int NUNITS = 1 << UNIT_W;
  localparam logic [2:0] OP_CON = 3'd0, OP_DIS = 3'd1, OP_SCH = 3'd2,
                         OP_SDT = 3'd3, OP_RCV = 3'd4;

  logic [NUNITS-1:0] conn_q;
  logic              valid_q, done_q, skip_q;
  logic [2:0]        op_q;
  logic [UNIT_W-1:0] unit_q;
  logic [REG_W-1:0]  reg_q, reg_out_q, ok_val;
  logic [TO_W-1:0]   cnt_q;

  wire accept  = start & ~valid_q & ~done_q;
  wire legal   = op <= OP_RCV;
  wire unit_ok = (op == OP_CON) | conn_q[unit];
  wire go      = accept & legal & unit_ok;
  wire bad     = accept & ~go;
  wire hs      = valid_q & req_ready;
  wire tmo     = valid_q & ~req_ready & (cnt_q == to_limit);

  always_comb begin
    case (op_q)
      OP_SCH:  ok_val = {reg_q[REG_W-CHAR_W-1:0], {CHAR_W{1'b0}}};
      OP_RCV:  ok_val = {{(REG_W-CHAR_W){1'b0}}, rsp_char};
      default: ok_val = reg_q;
    endcase
  end

  always_comb begin
    req_data = '0;
    case (op_q)
      OP_SCH:  req_data[CHAR_W-1:0] = reg_q[REG_W-1 -: CHAR_W];
      OP_SDT:  req_data[DATA_W-1:0] = reg_q[DATA_W-1:0];
      default: req_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conn_q    <= '0;
      valid_q   <= 1'b0;
      done_q    <= 1'b0;
      skip_q    <= 1'b0;
      op_q      <= '0;
      unit_q    <= '0;
      reg_q     <= '0;
      reg_out_q <= '0;
      cnt_q     <= '0;
    end else begin
      done_q <= bad | hs | tmo;
      skip_q <= 1'b0;
      if (bad) reg_out_q <= reg_in;
      if (go) begin
        valid_q <= 1'b1;
        op_q    <= op;
        unit_q  <= unit;
        reg_q   <= reg_in;
        cnt_q   <= '0;
      end
      if (hs) begin
        valid_q   <= 1'b0;
        skip_q    <= 1'b1;
        reg_out_q <= ok_val;
        if (op_q == OP_CON) conn_q[unit_q] <= 1'b1;
        if (op_q == OP_DIS) conn_q[unit_q] <= 1'b0;
      end else if (tmo) begin
        valid_q   <= 1'b0;
        reg_out_q <= reg_q;
      end else if (valid_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy       = valid_q | done_q;
  assign done       = done_q;
  assign skip       = skip_q;
  assign reg_out    = reg_out_q;
  assign req_valid  = valid_q;
  assign req_unit   = unit_q;
  assign req_op     = op_q;
  assign kbd_unlock = conn_q[KBD_UNIT];
endmodule

// File: rtl/char_io_channel_chk.sv
module char_io_channel_chk #(
  parameter int REG_W  = 24,
  parameter int CHAR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             skip,
  input logic [REG_W-1:0] reg_out,
  input logic             req_valid,
  input logic             req_ready,
  input logic [2:0]       req_op,
  input logic [REG_W-1:0] req_data
);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_skip_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> done);
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> $stable(req_op));
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> done || (req_valid && $stable(req_data)));
  assert_done_after_hs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> done && skip && !req_valid);
  assert_recv_upper_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && skip && req_op == 3'd4 |-> reg_out[REG_W-1:CHAR_W] == '0);
  assert_sendchar_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && skip && req_op == 3'd2 |-> reg_out[CHAR_W-1:0] == '0);
endmodule

bind char_io_channel char_io_channel_chk #(.REG_W(REG_W), .CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .skip(skip),
  .reg_out(reg_out), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_data(req_data)
);

// File: tb/char_io_channel_tb.sv
module char_io_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  localparam int TO = 10;
  localparam logic [7:0] NEVER = 8'd255;

  localparam logic [2:0]  V_OP  [NV] = '{3'd2, 3'd0, 3'd2, 3'd3, 3'd0, 3'd4, 3'd4, 3'd1, 3'd3, 3'd6, 3'd0, 3'd2, 3'd7};
  localparam logic [5:0]  V_UN  [NV] = '{6'd8, 6'd8, 6'd8, 6'd8, 6'd12, 6'd12, 6'd12, 6'd8, 6'd8, 6'd12, 6'd9, 6'd9, 6'd12};
  localparam logic [23:0] V_REG [NV] = '{24'hABCDEF, 24'h000111, 24'hABCDEF, 24'h123456, 24'h000000,
                                         24'hFFFFFF, 24'hFFFFFF, 24'h000042, 24'h123456, 24'h00ABCD,
                                         24'h000005, 24'h000001, 24'h0000FF};
  localparam logic [7:0]  V_DLY [NV] = '{8'd0, 8'd2, 8'd0, 8'd1, 8'd0, 8'd3, NEVER, 8'd0, 8'd0, 8'd0, NEVER, 8'd0, 8'd0};
  localparam logic [5:0]  V_RSP [NV] = '{6'h0, 6'h0, 6'h0, 6'h0, 6'h0, 6'h25, 6'h0, 6'h0, 6'h0, 6'h0, 6'h0, 6'h0, 6'h0};
  localparam bit          V_REQ [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [23:0] V_DAT [NV] = '{24'h0, 24'h0, 24'h00002A, 24'h000456, 24'h0, 24'h0, 24'h0,
                                         24'h0, 24'h0, 24'h0, 24'h0, 24'h0, 24'h0};
  localparam bit          V_SKP [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [23:0] V_EXP [NV] = '{24'hABCDEF, 24'h000111, 24'hF37BC0, 24'h123456, 24'h000000,
                                         24'h000025, 24'hFFFFFF, 24'h000042, 24'h123456, 24'h00ABCD,
                                         24'h000005, 24'h000001, 24'h0000FF};

  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] op = 0;
  logic [5:0] unit = 0;
  logic [23:0] reg_in = 0;
  logic [15:0] to_limit = 16'(TO);
  logic busy, done, skip, req_valid, kbd_unlock;
  logic [23:0] reg_out, req_data;
  logic [5:0] req_unit;
  logic [2:0] req_op;
  logic req_ready = 0;
  logic [5:0] rsp_char = 0;

  int checks = 0, fails = 0;
  logic [7:0] cur_dly = 0;
  logic [5:0] cur_rsp = 0;
  int wcnt = 0, req_cycles = 0;
  bit seen = 0;
  logic [23:0] cap_data;
  logic [5:0] cap_unit;
  logic [2:0] cap_op;

  char_io_channel u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .unit(unit), .reg_in(reg_in),
    .to_limit(to_limit), .busy(busy), .done(done), .skip(skip), .reg_out(reg_out),
    .req_valid(req_valid), .req_unit(req_unit), .req_op(req_op), .req_data(req_data),
    .req_ready(req_ready), .rsp_char(rsp_char), .kbd_unlock(kbd_unlock)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tag_of(int i);
    case (V_OP[i])
      3'd0: return V_SKP[i] ? "R3" : "R9";
      3'd1: return "R4";
      3'd2: return V_REQ[i] ? "R5" : "R8";
      3'd3: return V_REQ[i] ? "R6" : "R8";
      3'd4: return V_SKP[i] ? "R7" : "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (req_ready) begin
      chk(done === 1'b1 && skip === 1'b1, "R11", {30'd0, done, skip}, 32'd3);
      req_ready = 0;
    end else if (req_valid) begin
      req_cycles++;
      seen = 1;
      cap_data = req_data;
      cap_unit = req_unit;
      cap_op = req_op;
      if (wcnt == int'(cur_dly)) begin
        req_ready = 1;
        rsp_char = cur_rsp;
      end else wcnt++;
    end else wcnt = 0;
  end

  task automatic run(input logic [2:0] o, input logic [5:0] u, input logic [23:0] r,
                     input logic [7:0] d, input logic [5:0] c, output bit sk,
                     output logic [23:0] ro, output int n);
    @(negedge clk);
    cur_dly = d; cur_rsp = c; seen = 0; req_cycles = 0;
    op = o; unit = u; reg_in = r; start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    sk = skip;
    ro = reg_out;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit sk;
    logic [23:0] ro;
    int n;
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && skip === 0 && req_valid === 0 && kbd_unlock === 0, "R1",
        {27'd0, busy, done, skip, req_valid, kbd_unlock}, 32'd0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      run(V_OP[i], V_UN[i], V_REG[i], V_DLY[i], V_RSP[i], sk, ro, n);
      chk(sk == V_SKP[i], tag_of(i), {31'd0, sk}, {31'd0, V_SKP[i]});
      chk(ro == V_EXP[i], tag_of(i), {8'd0, ro}, {8'd0, V_EXP[i]});
      chk(seen == V_REQ[i], tag_of(i), {31'd0, seen}, {31'd0, V_REQ[i]});
      if (V_REQ[i]) begin
        chk(cap_data == V_DAT[i] && cap_unit == V_UN[i] && cap_op == V_OP[i], "R2",
            {cap_op, cap_unit, cap_data[22:0]}, {V_OP[i], V_UN[i], V_DAT[i][22:0]});
        if (V_DLY[i] == NEVER)
          chk(req_cycles == TO + 1, "R9", req_cycles, TO + 1);
      end else begin
        chk(n == 0, "R8", n, 0);
      end
    end

    chk(kbd_unlock === 1'b1, "R3", {31'd0, kbd_unlock}, 1);
    run(3'd1, 6'd12, 24'h0, 8'd0, 6'd0, sk, ro, n);
    chk(sk == 1'b1 && kbd_unlock === 1'b0, "R4", {30'd0, sk, kbd_unlock}, 32'd2);

    // R10: second start during a pending connect is ignored
    @(negedge clk);
    cur_dly = NEVER; seen = 0; req_cycles = 0;
    op = 3'd0; unit = 6'd20; reg_in = 0; start = 1;
    @(negedge clk);
    unit = 6'd21; reg_in = 24'h777;
    repeat (3) @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    chk(skip === 1'b0 && req_cycles == TO + 1 && cap_unit == 6'd20, "R10",
        {26'd0, cap_unit}, 32'd20);
    chk(reg_out == 24'h0, "R10", {8'd0, reg_out}, 0);
    run(3'd3, 6'd21, 24'h1, 8'd0, 6'd0, sk, ro, n);
    chk(sk == 1'b0 && !seen, "R10", {30'd0, sk, seen}, 0);

    // R1: reset forgets a connection
    run(3'd0, 6'd30, 24'h0, 8'd0, 6'd0, sk, ro, n);
    chk(sk == 1'b1, "R3", {31'd0, sk}, 1);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    run(3'd3, 6'd30, 24'h5, 8'd0, 6'd0, sk, ro, n);
    chk(sk == 1'b0 && !seen && ro == 24'h5, "R1", {30'd0, sk, seen}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule